// File: doc/BRIEF.md
# Multi-Mode Interval Timer Channel

This block is one channel of an interval timer: a 16-bit down counter that advances once per count tick and drives a single waveform output. A register block beside it decodes the host bus. That register block hands this channel three things: a mode select with a binary/BCD flag, the initial count, and a flag that says a count write is only half done. The channel can produce the following:

- a level that rises at terminal count
- a gate-triggered one-shot pulse
- a periodic one-tick rate pulse
- a square wave
- a single-tick strobe, started either by a count write or by a gate edge

The gate input has one of three roles, depending on the mode. In some modes it pauses counting. In others its rising edge starts or restarts the count. In the periodic modes it does both, and it also forces the output high. The current count is available on an output port, so the register block can latch it for readback.

Writes are single-cycle strobes that are accepted in every cycle. There is no back-pressure: a configuration write and a count write never stall. `cnt_tick` is a clock enable on `clk`, and every counting action happens only on a `clk` edge where `cnt_tick` is high. A gate rising edge is registered at the `clk` edge where it is first seen, and it takes effect on the first tick after that edge. A count that is loaded from a write is taken on the first tick after the write edge.

Top module: `tmr_channel`

## Requirements
- R1: The count changes only on a clock edge with `cnt_tick` high. When the count steps, it moves down by one, or by two in the square-wave mode. `cur_count` always shows the live count.
- R2: `cfg_mode` codes 0 to 5 select the six modes. Codes 6 and 7 behave exactly like codes 2 and 3.
- R3: Mode 0 (rise at terminal count):
  - A configuration write or a count write drives `tmr_out` low at the next edge.
  - The count N is loaded on the next tick.
  - `tmr_out` rises N+1 ticks after the write edge and stays high.
- R4: In mode 0, counting pauses while `gate` is low or while `cnt_hold` is high.
- R5: Mode 1 (one-shot):
  - A `gate` rising edge loads N on the next tick and drives `tmr_out` low.
  - `tmr_out` goes high N ticks later.
  - Another rising edge during the pulse restarts it.
  - A count written during the pulse takes effect only at the next trigger.
- R6: Mode 2 (rate):
  - `tmr_out` goes low for exactly one tick every N ticks.
  - The first low tick comes N ticks after the write edge.
  - A count written while running takes effect at the next reload.
- R7: Mode 3 (square wave), with period N:
  - `tmr_out` is high for ceil(N/2) ticks and low for floor(N/2) ticks.
  - A new count takes effect at the next half-period boundary.
- R8: In modes 2 and 3, a low `gate` forces `tmr_out` high at the next edge and pauses counting. A `gate` rising edge reloads the count on the next tick and starts a new high phase.
- R9: Mode 4 (software strobe):
  - `tmr_out` stays high, except for a single-tick low pulse N+1 ticks after the count write edge.
  - A low `gate` pauses counting.
- R10: Mode 5 (hardware strobe): `tmr_out` pulses low for one tick N+1 ticks after a `gate` rising edge. Each later rising edge reloads N.
- R11: With `cfg_bcd` = 1, the count is four BCD digits, least significant digit in bits 3:0, and it steps 0100 to 0099. A count of 0 lasts 65536 ticks in binary and 10000 ticks in BCD.
- R12: After reset, `tmr_out` is 0 and `cur_count` is 0. The channel starts in mode 0 with nothing loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count clock enable, one tick per high cycle |
| gate | input | 1 | Gate level and trigger input |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code (6, 7 alias 2, 3) |
| cfg_bcd | input | 1 | 1 selects BCD counting |
| cnt_wr | input | 1 | Count write strobe |
| cnt_val | input | 16 | Initial count value |
| cnt_hold | input | 1 | Count write half done; pauses mode 0 |
| tmr_out | output | 1 | Timer waveform output |
| cur_count | output | 16 | Live count value |

## Verification
The bench sweeps the count through small values in every mode and measures each high and low run against the lengths that follow from N. Odd counts in the square-wave mode catch a design that splits the period evenly, because that design would give equal halves. Zero counts in binary and in BCD catch a design that expires at once instead of running 65536 or 10000 ticks. Mid-period rewrites and retriggers are also exercised, along with gate and hold pauses: a design that applies a rate count immediately, ignores a retrigger, or lets the count drift while paused gives a wrong run length or a changed `cur_count`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_INTR    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  // codes 6 and 7 drop their top bit
  function automatic mode_e norm_mode(input logic [2:0] code);
    if (code[2] && code[1]) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

endpackage

// File: rtl/tmr_dec.sv
// One-step decrement, binary or packed BCD (W a multiple of 4).
module tmr_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] res
);
  localparam int ND = W / 4;

  logic [W-1:0]  bres;
  logic [ND-1:0] brw;

  assign brw[0] = 1'b1;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [3:0] d;
    assign d = val[4*i +: 4];
    assign bres[4*i +: 4] = !brw[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (i < ND - 1) begin : g_brw
      assign brw[i+1] = brw[i] & (d == 4'd0);
    end
  end

  assign res = bcd ? bres : val - W'(1);
endmodule

// File: rtl/tmr_gate_trig.sv
// Gate rising-edge capture; pending until the next tick consumes it.
module tmr_gate_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic clr,
  input  logic ack,
  output logic pend
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      gate_q <= gate;
      if (clr)                pend <= 1'b0;
      else if (gate && !gate_q) pend <= 1'b1;
      else if (ack)           pend <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          gate,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_bcd,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_hold,
  output logic          tmr_out,
  output logic [CW-1:0] cur_count
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  mode_e         mode_q;
  logic          bcd_q;
  logic [CW-1:0] init_q, cnt_q;
  logic          out_q, load_pend_q, loaded_q, have_cnt_q, fired_q, ext_q;
  logic          trig;
  logic [CW-1:0] dec1, dec2, init_even;
  logic          is_wave;

  tmr_gate_trig u_trig (
    .clk (clk), .rst_n (rst_n), .gate (gate),
    .clr (cfg_wr), .ack (cnt_tick), .pend (trig)
  );

  tmr_dec #(.W(CW)) u_dec1 (.val(cnt_q), .bcd(bcd_q), .res(dec1));
  tmr_dec #(.W(CW)) u_dec2 (.val(dec1),  .bcd(bcd_q), .res(dec2));

  assign init_even = {init_q[CW-1:1], 1'b0};
  assign is_wave   = (mode_q == M_RATE) || (mode_q == M_SQUARE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= M_INTR;
      bcd_q       <= 1'b0;
      init_q      <= '0;
      cnt_q       <= '0;
      out_q       <= 1'b0;
      load_pend_q <= 1'b0;
      loaded_q    <= 1'b0;
      have_cnt_q  <= 1'b0;
      fired_q     <= 1'b1;
      ext_q       <= 1'b0;
    end else if (cfg_wr) begin
      mode_q      <= norm_mode(cfg_mode);
      bcd_q       <= cfg_bcd;
      out_q       <= (norm_mode(cfg_mode) != M_INTR);
      load_pend_q <= 1'b0;
      loaded_q    <= 1'b0;
      have_cnt_q  <= 1'b0;
      fired_q     <= 1'b1;
      ext_q       <= 1'b0;
    end else begin
      if (is_wave && !gate) out_q <= 1'b1;

      if (cnt_tick) begin
        case (mode_q)
          M_INTR: begin
            if (load_pend_q) begin
              cnt_q <= init_q; load_pend_q <= 1'b0; loaded_q <= 1'b1;
            end else if (loaded_q && gate && !cnt_hold) begin
              cnt_q <= dec1;
              if (cnt_q == ONE) out_q <= 1'b1;
            end
          end
          M_ONESHOT: begin
            if (trig && have_cnt_q) begin
              cnt_q <= init_q; out_q <= 1'b0; loaded_q <= 1'b1;
            end else if (loaded_q) begin
              cnt_q <= dec1;
              if (cnt_q == ONE) out_q <= 1'b1;
            end
          end
          M_RATE: begin
            if (load_pend_q || (trig && loaded_q)) begin
              cnt_q <= init_q; out_q <= 1'b1;
              load_pend_q <= 1'b0; loaded_q <= 1'b1;
            end else if (loaded_q && gate) begin
              if (cnt_q == ONE) begin
                cnt_q <= init_q; out_q <= 1'b1;
              end else begin
                cnt_q <= dec1;
                if (cnt_q == TWO) out_q <= 1'b0;
              end
            end
          end
          M_SQUARE: begin
            if (load_pend_q || (trig && loaded_q)) begin
              cnt_q <= init_even; out_q <= 1'b1; ext_q <= 1'b0;
              load_pend_q <= 1'b0; loaded_q <= 1'b1;
            end else if (loaded_q && gate) begin
              if (ext_q) begin
                ext_q <= 1'b0; out_q <= 1'b0; cnt_q <= init_even;
              end else if (cnt_q == TWO) begin
                if (out_q && init_q[0]) begin
                  ext_q <= 1'b1; cnt_q <= dec2;
                end else begin
                  out_q <= !out_q; cnt_q <= init_even;
                end
              end else begin
                cnt_q <= dec2;
              end
            end
          end
          M_SWSTB, M_HWSTB: begin
            if (!out_q) out_q <= 1'b1;
            if ((mode_q == M_SWSTB) ? load_pend_q : (trig && have_cnt_q)) begin
              cnt_q <= init_q; load_pend_q <= 1'b0;
              loaded_q <= 1'b1; fired_q <= 1'b0;
            end else if (loaded_q && (gate || mode_q == M_HWSTB)) begin
              cnt_q <= dec1;
              if (cnt_q == ONE && !fired_q) begin
                out_q <= 1'b0; fired_q <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end

      if (cnt_wr) begin
        init_q     <= cnt_val;
        have_cnt_q <= 1'b1;
        case (mode_q)
          M_INTR:            begin out_q <= 1'b0; load_pend_q <= 1'b1; end
          M_SWSTB:           load_pend_q <= 1'b1;
          M_RATE, M_SQUARE:  if (!loaded_q) load_pend_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign tmr_out   = out_q;
  assign cur_count = cnt_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_tick,
  input logic          gate,
  input logic          cfg_wr,
  input logic          cnt_wr,
  input logic          tmr_out,
  input logic [CW-1:0] cur_count,
  input logic [2:0]    mode_q
);
  // R1: no tick, no count change
  assert_count_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(cur_count));

  // R3: mode 0 count write drives the output low
  assert_intr_write_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && cnt_wr && mode_q == 3'(M_INTR)) |=> !tmr_out);

  // R6: rate pulse lasts a single tick
  assert_rate_pulse_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'(M_RATE) && !tmr_out && cnt_tick && !cfg_wr) |=> tmr_out);

  // R8: gate low forces output high in periodic modes
  assert_gate_forces_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !gate && (mode_q == 3'(M_RATE) || mode_q == 3'(M_SQUARE))) |=> tmr_out);

  // R9: software strobe lasts a single tick
  assert_strobe_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'(M_SWSTB) && !tmr_out && cnt_tick && !cfg_wr) |=> tmr_out);
endmodule

bind tmr_channel tmr_channel_chk #(.CW(CW)) u_chk (
  .clk (clk), .rst_n (rst_n), .cnt_tick (cnt_tick), .gate (gate),
  .cfg_wr (cfg_wr), .cnt_wr (cnt_wr), .tmr_out (tmr_out),
  .cur_count (cur_count), .mode_q (mode_q)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b1;
  logic        gate = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cfg_bcd = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_val = 16'd0;
  logic        cnt_hold = 1'b0;
  logic        tmr_out;
  logic [15:0] cur_count;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmr_channel dut (
    .clk (clk), .rst_n (rst_n), .cnt_tick (cnt_tick), .gate (gate),
    .cfg_wr (cfg_wr), .cfg_mode (cfg_mode), .cfg_bcd (cfg_bcd),
    .cnt_wr (cnt_wr), .cnt_val (cnt_val), .cnt_hold (cnt_hold),
    .tmr_out (tmr_out), .cur_count (cur_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic until_lvl(input logic lvl, output int k);
    k = 0;
    do begin
      @(posedge clk); @(negedge clk); k++;
    end while (tmr_out != lvl && k < 70000);
  endtask

  task automatic do_cfg(input logic [2:0] m, input logic b);
    cfg_wr = 1'b1; cfg_mode = m; cfg_bcd = b;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_wr(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_val = v;
    @(posedge clk); @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic gate_rise();
    gate = 1'b0; step(1);
    gate = 1'b1; @(posedge clk); @(negedge clk);
  endtask

  // periodic mode: first fall, then low and high run lengths
  task automatic wave(input string req, input int first, input int lo, input int hi);
    int k;
    until_lvl(1'b0, k); chk(req, k, first);
    until_lvl(1'b1, k); chk(req, k, lo);
    until_lvl(1'b0, k); chk(req, k, hi);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    logic [15:0] c;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    chk("R12 out", int'(tmr_out), 0);
    chk("R12 count", int'(cur_count), 0);

    // R3: mode 0 sweep
    for (int n = 1; n <= 12; n++) begin
      do_cfg(3'd0, 1'b0);
      chk("R3 cfg low", int'(tmr_out), 0);
      do_wr(16'(n));
      until_lvl(1'b1, k); chk("R3 rise", k, n + 1);
      step(5); chk("R3 stays high", int'(tmr_out), 1);
    end

    // R4: gate pause and hold pause in mode 0
    do_cfg(3'd0, 1'b0); do_wr(16'd10); step(3);
    gate = 1'b0; c = cur_count; chk("R4 count", int'(c), 8);
    step(5);
    chk("R4 gate pause", int'(cur_count), int'(c));
    chk("R4 out low", int'(tmr_out), 0);
    gate = 1'b1; until_lvl(1'b1, k); chk("R4 resume", k, 8);
    do_cfg(3'd0, 1'b0); do_wr(16'd10); step(2);
    cnt_hold = 1'b1; step(3);
    chk("R4 hold pause", int'(cur_count), 9);
    cnt_hold = 1'b0; until_lvl(1'b1, k); chk("R4 hold resume", k, 9);

    // R5: one-shot sweep, retrigger, deferred write
    for (int n = 1; n <= 8; n++) begin
      do_cfg(3'd1, 1'b0); do_wr(16'(n)); step(2);
      chk("R5 idle high", int'(tmr_out), 1);
      gate_rise();
      until_lvl(1'b0, k); chk("R5 start", k, 1);
      until_lvl(1'b1, k); chk("R5 width", k, n);
    end
    do_cfg(3'd1, 1'b0); do_wr(16'd10);
    gate_rise(); step(2); gate_rise();
    until_lvl(1'b1, k); chk("R5 retrigger", k, 11);
    do_cfg(3'd1, 1'b0); do_wr(16'd6);
    gate_rise(); step(1); do_wr(16'd12);
    until_lvl(1'b1, k); chk("R5 pulse kept", k, 5);
    gate_rise();
    until_lvl(1'b0, k); chk("R5 new start", k, 1);
    until_lvl(1'b1, k); chk("R5 new width", k, 12);

    // R6: rate sweep
    for (int n = 2; n <= 16; n++) begin
      do_cfg(3'd2, 1'b0); do_wr(16'(n));
      wave("R6 rate", n, 1, n - 1);
    end
    do_cfg(3'd2, 1'b0); do_wr(16'd5);
    until_lvl(1'b0, k); do_wr(16'd8);
    until_lvl(1'b0, k); chk("R6 deferred old", k, 4);
    until_lvl(1'b1, k); chk("R6 deferred low", k, 1);
    until_lvl(1'b0, k); chk("R6 deferred new", k, 7);

    // R7: square sweep
    for (int n = 2; n <= 17; n++) begin
      do_cfg(3'd3, 1'b0); do_wr(16'(n));
      wave("R7 square", (n + 1) / 2 + 1, n / 2, (n + 1) / 2);
    end

    // R2: aliases
    do_cfg(3'd6, 1'b0); do_wr(16'd7); wave("R2 code6", 7, 1, 6);
    do_cfg(3'd7, 1'b0); do_wr(16'd7); wave("R2 code7", 5, 3, 4);

    // R8: gate in square mode
    do_cfg(3'd3, 1'b0); do_wr(16'd10);
    until_lvl(1'b0, k);
    gate = 1'b0; step(1);
    chk("R8 forced high", int'(tmr_out), 1);
    c = cur_count; step(4);
    chk("R8 paused", int'(cur_count), int'(c));
    gate = 1'b1; @(posedge clk); @(negedge clk);
    until_lvl(1'b0, k); chk("R8 restart", k, 6);

    // R9: software strobe sweep
    for (int n = 1; n <= 10; n++) begin
      do_cfg(3'd4, 1'b0); do_wr(16'(n));
      until_lvl(1'b0, k); chk("R9 strobe", k, n + 1);
      until_lvl(1'b1, k); chk("R9 width", k, 1);
    end

    // R1: tick low freezes count
    do_cfg(3'd4, 1'b0); do_wr(16'd20); step(2);
    cnt_tick = 1'b0; step(4);
    chk("R1 frozen", int'(cur_count), 19);
    chk("R1 out", int'(tmr_out), 1);
    cnt_tick = 1'b1;
    until_lvl(1'b0, k); chk("R1 resume", k, 19);

    // R10: hardware strobe sweep
    for (int n = 1; n <= 10; n++) begin
      do_cfg(3'd5, 1'b0); do_wr(16'(n)); step(3);
      chk("R10 idle high", int'(tmr_out), 1);
      gate_rise();
      until_lvl(1'b0, k); chk("R10 strobe", k, n + 1);
      until_lvl(1'b1, k); chk("R10 width", k, 1);
    end

    // R11: BCD stepping and zero counts
    do_cfg(3'd0, 1'b1); do_wr(16'h0100); step(2);
    chk("R11 bcd step", int'(cur_count), 16'h0099);
    until_lvl(1'b1, k); chk("R11 bcd run", k, 99);
    do_cfg(3'd3, 1'b1); do_wr(16'h0011); wave("R11 bcd square", 7, 5, 6);
    do_cfg(3'd0, 1'b1); do_wr(16'h0000);
    until_lvl(1'b1, k); chk("R11 bcd zero", k, 10001);
    do_cfg(3'd0, 1'b0); do_wr(16'h0000);
    until_lvl(1'b1, k); chk("R11 bin zero", k, 65537);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule